// File: doc/BRIEF.md
# VGA raster timing generator

This block walks a raster of 640 by 480 visible pixels and produces the signals a monitor needs to follow it. It advances once per pixel-clock enable (one enable per pixel at 25 MHz gives about 60 frames per second, 32 us per line and about 16.7 ms per frame). A line takes 800 enables: 640 visible pixels, then 16 of front porch, 96 of horizontal sync and 48 of back porch. A frame takes 521 lines: 480 visible lines, then 10 of front porch, 2 of vertical sync and 29 of back porch. The line counter steps exactly when the pixel counter wraps, and both counters run without pause for as long as enables arrive.

An upstream pixel source supplies a 12-bit colour, four bits each for red, green and blue. The block forwards that colour during the visible area and forces it to zero in every porch and sync interval. The current pixel column and row come out while the display is enabled, so a frame-buffer address can be formed from them. A one-cycle start-of-frame pulse marks the top-left pixel. Every interval length is a parameter, so the same block can serve other raster sizes.

Top module: `vga_raster_gen`

## Requirements
- R1: The column counter counts pixel enables from 0 to H_VIS+H_FP+H_SYNC+H_BP-1 (799 by default) and then wraps to 0; a line is exactly that many enables long.
- R2: The row counter advances by one only on the enable that wraps the column counter, and wraps after V_VIS+V_FP+V_SYNC+V_BP rows (521 by default); a frame is the product of both totals in enables.
- R3: `hsync_n` is low exactly while the column lies in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC-1] and high otherwise, so each low pulse lasts H_SYNC enables.
- R4: `vsync_n` is low exactly while the row lies in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC-1] and high otherwise, so each low pulse lasts V_SYNC full lines.
- R5: `disp_en` is high exactly when the column is below H_VIS and the row is below V_VIS.
- R6: `rgb_out` equals `rgb_in` while `disp_en` is high and is all zeros otherwise; red sits in bits [11:8], green in [7:4] and blue in [3:0] of both buses, and the same positions are used on input and output.
- R7: While `disp_en` is high, `pix_x` and `pix_y` give the column and row, counted from 0 at the top-left visible pixel. While it is low, both read 0.
- R8: `sof` is high only in the cycle where `pix_en` is high and the position is column 0, row 0, so it occurs once per frame.
- R9: While `pix_en` is low, the position does not change, and no output other than `rgb_out` and `sof` changes either (`rgb_out` follows R6).
- R10: While `rst_n` is low at a clock edge, the position is set to column 0, row 0. Both syncs are then high (deasserted), and `disp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable, one per pixel period |
| rgb_in | input | 12 | Upstream pixel colour (R[11:8], G[7:4], B[3:0]) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | High inside the visible area |
| pix_x | output | 10 | Visible column, 0 outside the visible area |
| pix_y | output | 10 | Visible row, 0 outside the visible area |
| sof | output | 1 | Start-of-frame pulse at the top-left pixel |
| rgb_out | output | 12 | Colour with blanking applied |

## Verification
The bench builds the block with a shrunken raster: 8 visible columns with porches and sync of 2, 3 and 2, and 4 visible rows with porches and sync of 1, 2 and 1. A frame is then 15 by 8 = 120 enables. This brings several whole frames within reach, so every boundary can be probed directly: the first and last visible pixel, each porch edge, the sync start and end on both axes, the line and frame wraps, and the spacing between start-of-frame pulses. The full-size defaults are covered by the same parameter arithmetic, and the assertions run with the bench's values.

// File: rtl/vga_timing_pkg.sv
// Package: shared constants and helpers for the raster timing generator.
// Assumes three colour channels of equal width, packed red-green-blue from MSB.
package vga_timing_pkg;

    localparam int CHANNELS = 3;

    // Sum of the four intervals that make up one axis period.
    function automatic int axis_total(input int vis, input int fp, input int sync, input int bp);
        return vis + fp + sync + bp;
    endfunction

endpackage

// File: rtl/vga_axis_counter.sv
// Module: vga_axis_counter
// One raster axis: a wrapping position counter plus decode of the visible
// and sync windows. Assumes every interval is at least one count long.
module vga_axis_counter import vga_timing_pkg::*; #(
    parameter int VIS  = 640,
    parameter int FP   = 16,
    parameter int SYNC = 96,
    parameter int BP   = 48,
    localparam int TOTAL = axis_total(VIS, FP, SYNC, BP),
    localparam int W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         active,
    output logic         in_sync
);

    localparam logic [W-1:0] LAST       = W'(TOTAL - 1);
    localparam logic [W-1:0] VIS_END    = W'(VIS);
    localparam logic [W-1:0] SYNC_FIRST = W'(VIS + FP);
    localparam logic [W-1:0] SYNC_LAST  = W'(VIS + FP + SYNC - 1);

    // Position register: clears on reset, steps and wraps on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Window decode from the current position.
    always_comb begin
        wrap    = step && (cnt == LAST);
        active  = (cnt < VIS_END);
        in_sync = (cnt >= SYNC_FIRST) && (cnt <= SYNC_LAST);
    end

endmodule

// File: rtl/vga_blank_mux.sv
// Module: vga_blank_mux
// Forces every colour channel to zero when the display is not enabled.
// Assumes CHANNELS channels of CH_W bits packed side by side.
module vga_blank_mux import vga_timing_pkg::*; #(
    parameter int CH_W = 4,
    localparam int BUS_W = CHANNELS * CH_W
) (
    input  logic             show,
    input  logic [BUS_W-1:0] color_in,
    output logic [BUS_W-1:0] color_out
);

    // One gate per channel.
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        assign color_out[ch*CH_W +: CH_W] = show ? color_in[ch*CH_W +: CH_W] : '0;
    end

endmodule

// File: rtl/vga_raster_gen.sv
// Module: vga_raster_gen (top)
// Raster timing generator: column and row counters, active-low syncs,
// display enable, visible coordinates, start-of-frame pulse and blanked
// colour. Assumes pix_en is a single-cycle enable per pixel period and
// that the upstream colour is aligned to the coordinates shown this cycle.
module vga_raster_gen import vga_timing_pkg::*; #(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 29,
    parameter int CH_W   = 4,
    localparam int H_TOTAL = axis_total(H_VIS, H_FP, H_SYNC, H_BP),
    localparam int V_TOTAL = axis_total(V_VIS, V_FP, V_SYNC, V_BP),
    localparam int X_W     = $clog2(H_TOTAL),
    localparam int Y_W     = $clog2(V_TOTAL),
    localparam int RGB_W   = CHANNELS * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [RGB_W-1:0] rgb_in,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             disp_en,
    output logic [X_W-1:0]   pix_x,
    output logic [Y_W-1:0]   pix_y,
    output logic             sof,
    output logic [RGB_W-1:0] rgb_out
);

    logic [X_W-1:0] h_cnt;
    logic [Y_W-1:0] v_cnt;
    logic h_wrap, h_act, h_sync;
    logic v_wrap, v_act, v_sync;

    // Column axis, stepped by the pixel enable.
    vga_axis_counter #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) i_h_axis (
        .clk(clk), .rst_n(rst_n), .step(pix_en),
        .cnt(h_cnt), .wrap(h_wrap), .active(h_act), .in_sync(h_sync)
    );

    // Row axis, stepped only when the column axis wraps.
    vga_axis_counter #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) i_v_axis (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .cnt(v_cnt), .wrap(v_wrap), .active(v_act), .in_sync(v_sync)
    );

    // Output decode: syncs, enable, coordinates and frame marker.
    always_comb begin
        hsync_n = ~h_sync;
        vsync_n = ~v_sync;
        disp_en = h_act & v_act;
        pix_x   = disp_en ? h_cnt : '0;
        pix_y   = disp_en ? v_cnt : '0;
        sof     = pix_en && (h_cnt == '0) && (v_cnt == '0);
    end

    // Colour blanking outside the visible area.
    vga_blank_mux #(.CH_W(CH_W)) i_blank (
        .show(disp_en), .color_in(rgb_in), .color_out(rgb_out)
    );

endmodule

// File: rtl/vga_raster_gen_checker.sv
// Module: vga_raster_gen_checker
// Concurrent properties on the raster generator, attached by bind.
// Assumes the same parameter values as the instance it is bound to.
module vga_raster_gen_checker #(
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 521,
    parameter int X_W     = 10,
    parameter int Y_W     = 10,
    parameter int RGB_W   = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic [X_W-1:0]   h_cnt,
    input logic [Y_W-1:0]   v_cnt,
    input logic             h_wrap,
    input logic             v_wrap,
    input logic             hsync_n,
    input logic             disp_en,
    input logic [X_W-1:0]   pix_x,
    input logic [Y_W-1:0]   pix_y,
    input logic             sof,
    input logic [RGB_W-1:0] rgb_out
);

    // R1: the column returns to 0 after its last value.
    a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && h_cnt == X_W'(H_TOTAL - 1)) |=> (h_cnt == '0));

    // R2: the row holds unless the column wraps.
    a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wrap |=> $stable(v_cnt));

    // R2: the end of a frame leads to the origin.
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |=> (h_cnt == '0 && v_cnt == '0));

    // R3: horizontal sync never overlaps the visible area.
    a_r3_hs_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !disp_en);

    // R6: colour is zero while blanked.
    a_r6_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (rgb_out == '0));

    // R7: coordinates are zero outside the visible area.
    a_r7_coord_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (pix_x == '0 && pix_y == '0));

    // R8: the frame pulse only appears at the visible origin.
    a_r8_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (disp_en && pix_x == '0 && pix_y == '0));

    // R9: no movement without an enable.
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(h_cnt) && $stable(v_cnt)));

    // R10: reset leads to the origin.
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (h_cnt == '0 && v_cnt == '0));

    // R1 range check: the column never exceeds its last value.
    always @(posedge clk) begin
        if (rst_n) begin
            a_r1_h_range: assert (h_cnt <= X_W'(H_TOTAL - 1));
        end
    end

endmodule

bind vga_raster_gen vga_raster_gen_checker #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .X_W(X_W), .Y_W(Y_W), .RGB_W(RGB_W)
) i_checker (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_wrap(h_wrap), .v_wrap(v_wrap), .hsync_n(hsync_n), .disp_en(disp_en),
    .pix_x(pix_x), .pix_y(pix_y), .sof(sof), .rgb_out(rgb_out)
);

// File: tb/test_vga_raster_gen.sv
// Bench: shrunken raster, table of probe points, then directed tests.
module test_vga_raster_gen;

    localparam int HV = 8, HF = 2, HS = 3, HB = 2;
    localparam int VV = 4, VF = 1, VS = 2, VB = 1;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FRAME = HT * VT;
    localparam int XW = $clog2(HT);
    localparam int YW = $clog2(VT);
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic [11:0] rgb_in = '0;
    logic hsync_n, vsync_n, disp_en, sof;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;
    logic [11:0] rgb_out;

    int tests = 0;
    int fails = 0;
    int n = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    vga_raster_gen #(
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .CH_W(4)
    ) i_vga_raster_gen (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .rgb_in(rgb_in),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en),
        .pix_x(pix_x), .pix_y(pix_y), .sof(sof), .rgb_out(rgb_out)
    );

    // Probe table: enable count since reset, and the colour to offer there.
    localparam int NV = 16;
    localparam int VEC_N [NV] = '{0, 7, 8, 9, 10, 12, 13, 14, 15, 59,
                                  60, 75, 104, 105, 119, 121};
    localparam logic [11:0] VEC_RGB [NV] = '{12'hFFF, 12'h123, 12'hABC, 12'h0F0,
                                             12'hF00, 12'h00F, 12'h555, 12'h777,
                                             12'h9A5, 12'h3C3, 12'hEEE, 12'h111,
                                             12'h808, 12'h246, 12'hBBB, 12'h5A5};

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output against the model of position n.
    task automatic check_pos(input int pos, input logic en);
        int h, v;
        bit de;
        h  = pos % HT;
        v  = (pos / HT) % VT;
        de = (h < HV) && (v < VV);
        chk("R3", "hsync_n", int'(hsync_n), int'(!(h >= HV + HF && h < HV + HF + HS)));
        chk("R4", "vsync_n", int'(vsync_n), int'(!(v >= VV + VF && v < VV + VF + VS)));
        chk("R5", "disp_en", int'(disp_en), int'(de));
        chk("R7", "pix_x", int'(pix_x), de ? h : 0);
        chk("R7", "pix_y", int'(pix_y), de ? v : 0);
        chk("R6", "rgb_out", int'(rgb_out), de ? int'(rgb_in) : 0);
        chk("R8", "sof", int'(sof), int'(en && h == 0 && v == 0));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(2 * HALF * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int hs_run, vs_run, last_sof, sof_seen;
        logic [XW-1:0] hx;
        logic [YW-1:0] hy;
        logic hh, hvv, hd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state.
        chk("R10", "hsync_n in reset", int'(hsync_n), 1);
        chk("R10", "vsync_n in reset", int'(vsync_n), 1);
        chk("R10", "disp_en in reset", int'(disp_en), 1);
        chk("R10", "pix_x in reset", int'(pix_x), 0);

        rst_n  = 1'b1;
        pix_en = 1'b1;
        n = 0;
        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 at each probe.
        for (int i = 0; i < NV; i++) begin
            while (n < VEC_N[i]) step();
            rgb_in = VEC_RGB[i];
            #1;
            check_pos(n, 1'b1);
        end

        // Two frames: sync pulse widths and frame period (R1 R2 R3 R4 R8).
        hs_run = 0; vs_run = 0; last_sof = -1; sof_seen = 0;
        for (int k = 0; k < 2 * FRAME + 2; k++) begin
            step();
            if (!hsync_n) hs_run++;
            else if (hs_run != 0) begin chk("R3", "hsync width", hs_run, HS); hs_run = 0; end
            if (!vsync_n) vs_run++;
            else if (vs_run != 0) begin chk("R4", "vsync width", vs_run, VS * HT); vs_run = 0; end
            if (sof) begin
                if (last_sof >= 0) chk("R2", "frame length", n - last_sof, FRAME);
                last_sof = n;
                sof_seen++;
            end
        end
        chk("R8", "sof count", sof_seen, 2);

        // R9: hold with the enable low, mid-line in the visible area.
        while ((n % FRAME) != HT + 3) step();
        pix_en = 1'b0;
        #1;
        hx = pix_x; hy = pix_y; hh = hsync_n; hvv = vsync_n; hd = disp_en;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9", "pix_x stall", int'(pix_x), int'(hx));
        chk("R9", "pix_y stall", int'(pix_y), int'(hy));
        chk("R9", "sync stall", int'({hh, hvv, hd}), int'({hsync_n, vsync_n, disp_en}));
        chk("R9", "pix_x value", int'(pix_x), 3);
        pix_en = 1'b1;
        step();
        check_pos(n, 1'b1);

        // R10: reset taken while inside the horizontal sync window.
        while ((n % HT) != HV + HF + 1) step();
        chk("R3", "hsync low before reset", int'(hsync_n), 0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "hsync_n after reset", int'(hsync_n), 1);
        chk("R10", "vsync_n after reset", int'(vsync_n), 1);
        chk("R10", "pix_x after reset", int'(pix_x), 0);
        chk("R10", "pix_y after reset", int'(pix_y), 0);
        rst_n = 1'b1;
        n = 0;
        #1;
        check_pos(n, 1'b1);
        repeat (HT + 2) step();
        check_pos(n, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule